// File: doc/BRIEF.md
# DDS Waveform Player with Midscale-Crossing Stop

This block plays an arbitrary waveform out of a sample table onto a parallel DAC bus. A phase accumulator advances by a frequency tuning word once per fixed sample period. Its upper bits index the table, and the fetched sample is shown on the bus one period later. The tuning word is taken from an input that software keeps up to date. The player does not follow every change of that word: it samples the word only once per group of three samples.

When the sampled word is zero, the player does not cut the waveform. It remembers on which side of midscale the current sample lies and keeps playing at the last frequency. At the first sample that would land on the other side, it drives midscale instead and parks. While parked it holds midscale and keeps watching the word. A nonzero word restarts playback from the phase where it stopped.

For doubling the sample rate, two instances can share one DAC through a wired sum. Each instance shows its sample for one half of the period and returns to zero for the other half. A phase-select input chooses the half.

Top module: `dds_zc_player`

## Requirements
- R1: Synchronous reset (`rst` high) puts midscale 0x200 on the held output, clears the accumulator and increment, and parks the player. The first sample played after reset is therefore table index 0.
- R2: The held output changes only at the period boundary, once every `PERIOD` (32) cycles, and stays constant in between.
- R3: With `rtzEn` high, `dacBus` reads 0 for the half period not selected by `phaseSel`. With `rtzEn` low, the held value is driven for the whole period.
- R4: While running, each boundary shows the sample read at the previous boundary. The table index is `acc >> IDX_SHIFT` (the top 8 bits by default). The accumulator then advances by the current increment, modulo 2^32.
- R5: The tuning word is sampled only at every third running boundary (the end of a group). A nonzero word sampled there becomes the increment from the next boundary on. Changes made between group ends have no effect until then.
- R6: A zero word at a group end starts the fade. Bit 9 of the sample shown at that boundary is recorded, and playback continues at the previous increment for as long as each new sample has the same bit 9.
- R7: The first fade sample whose bit 9 differs is never shown. Midscale 0x200 is driven in its place, and the player parks.
- R8: While parked, midscale is held and the accumulator is frozen. The first boundary that sees a nonzero word loads it as the increment and advances the phase. The first new sample appears one boundary later.
- R9: Table initialisation writes take effect only for addresses from `TBL_BASE` (16384) to `TBL_BASE`+255. The entry written is the address minus `TBL_BASE`. Writes outside that window leave the table unchanged.
- R10: With `phaseSel` low, the boundary falls where the period counter wraps to 0, and the sample is driven in counts 0 to 15. With `phaseSel` high, the boundary falls at count 16, and the sample is driven in counts 16 to 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| freqWord | input | 32 | Frequency tuning word; zero requests a stop |
| phaseSel | input | 1 | Selects the half period in which the sample is driven |
| rtzEn | input | 1 | Return-to-zero enable for the unselected half |
| initWe | input | 1 | Table write strobe |
| initAddr | input | 15 | Table write address in sample memory space |
| initData | input | 10 | Table write data |
| dacBus | output | 10 | Parallel DAC output |

## Verification
The assertions assume that reset is asserted at the first clock edge. They also assume that `phaseSel` does not change while the player runs, because moving the boundary in mid-period would shorten one period. The bench holds `phaseSel` fixed for the whole of each reset-to-reset run and changes `rtzEn` and `freqWord` only just after an inactive-half sample point, well clear of any boundary. The table is filled while reset is held, so every index the accumulator can reach holds a known value before the first read.

// File: rtl/dds_pkg.sv
package dds_pkg;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_RUN  = 2'd1,
    ST_FADE = 2'd2
  } playState_t;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic tick;        // period boundary
    logic accStep;     // acc += inc
    logic accLoadNew;  // inc = freqWord, acc += freqWord (restart)
    logic incLoad;     // inc = freqWord (group end)
    logic outSample;   // held value = table read data
    logic outMid;      // held value = midscale
    logic driveOn;     // drive held value on the bus this cycle
  } ctlStb_t;

endpackage

// File: rtl/dds_table.sv
module dds_table #(
  parameter int DATA_W = 10,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrIdx] <= wrData;
    if (rdEn) rdData <= mem[rdIdx];
  end
endmodule

// File: rtl/dds_ctrl.sv
module dds_ctrl
  import dds_pkg::*;
#(
  parameter int PERIOD  = 32,
  parameter int GRP_LEN = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       phaseSel,
  input  logic       rtzEn,
  input  logic       freqZero,
  input  logic       sampleMsb,
  output ctlStb_t    stb,
  output playState_t curState
);
  localparam int CNT_W = $clog2(PERIOD);
  localparam int HALF  = PERIOD / 2;
  localparam int GRP_W = (GRP_LEN > 1) ? $clog2(GRP_LEN) : 1;

  logic [CNT_W-1:0] cnt;
  logic [GRP_W-1:0] grp;
  logic             side;
  playState_t       state;
  logic             tick;
  logic             activeHalf;
  logic             grpEnd;
  logic             crossed;

  assign tick = (cnt == (phaseSel ? CNT_W'(HALF - 1) : CNT_W'(PERIOD - 1)));
  assign activeHalf = phaseSel ? (cnt >= CNT_W'(HALF)) : (cnt < CNT_W'(HALF));
  assign grpEnd = (grp == GRP_W'(GRP_LEN - 1));
  assign crossed = (sampleMsb != side);
  assign curState = state;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (cnt == CNT_W'(PERIOD - 1)) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  always_comb begin
    stb = '0;
    stb.tick = tick;
    stb.driveOn = !rtzEn || activeHalf;
    if (tick) begin
      unique case (state)
        ST_WAIT: stb.accLoadNew = !freqZero;
        ST_RUN: begin
          stb.outSample = 1'b1;
          stb.accStep   = 1'b1;
          stb.incLoad   = grpEnd && !freqZero;
        end
        ST_FADE: begin
          if (crossed) begin
            stb.outMid = 1'b1;
          end else begin
            stb.outSample = 1'b1;
            stb.accStep   = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_WAIT;
      grp   <= '0;
      side  <= 1'b0;
    end else if (tick) begin
      unique case (state)
        ST_WAIT: begin
          if (!freqZero) begin
            state <= ST_RUN;
            grp   <= '0;
          end
        end
        ST_RUN: begin
          if (grpEnd) begin
            grp <= '0;
            if (freqZero) begin
              state <= ST_FADE;
              side  <= sampleMsb;
            end
          end else begin
            grp <= grp + 1'b1;
          end
        end
        ST_FADE: if (crossed) state <= ST_WAIT;
        default: state <= ST_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/dds_datapath.sv
module dds_datapath
  import dds_pkg::*;
#(
  parameter int ACC_W     = 32,
  parameter int IDX_SHIFT = 24,
  parameter int DATA_W    = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ctlStb_t                    stb,
  input  logic [ACC_W-1:0]           freqWord,
  input  logic                       tblWe,
  input  logic [ACC_W-IDX_SHIFT-1:0] tblWrIdx,
  input  logic [DATA_W-1:0]          tblWrData,
  output logic [DATA_W-1:0]          dacBus,
  output logic [DATA_W-1:0]          heldVal,
  output logic                       sampleMsb
);
  localparam int IDX_W = ACC_W - IDX_SHIFT;
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  inc;
  logic [DATA_W-1:0] rdData;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      inc <= '0;
    end else if (stb.accLoadNew) begin
      acc <= acc + freqWord;
      inc <= freqWord;
    end else begin
      if (stb.accStep) acc <= acc + inc;
      if (stb.incLoad) inc <= freqWord;
    end
  end

  dds_table #(.DATA_W(DATA_W), .IDX_W(IDX_W)) table_i (
    .clk   (clk),
    .rdEn  (stb.tick),
    .rdIdx (acc[ACC_W-1:IDX_SHIFT]),
    .rdData(rdData),
    .wrEn  (tblWe),
    .wrIdx (tblWrIdx),
    .wrData(tblWrData)
  );

  always_ff @(posedge clk) begin
    if (rst) heldVal <= MID;
    else if (stb.outMid) heldVal <= MID;
    else if (stb.outSample) heldVal <= rdData;
  end

  assign sampleMsb = rdData[DATA_W-1];
  assign dacBus = stb.driveOn ? heldVal : '0;
endmodule

// File: rtl/dds_zc_player.sv
module dds_zc_player
  import dds_pkg::*;
#(
  parameter int ACC_W     = 32,
  parameter int IDX_SHIFT = 24,
  parameter int DATA_W    = 10,
  parameter int PERIOD    = 32,
  parameter int GRP_LEN   = 3,
  parameter int ADDR_W    = 15,
  parameter int TBL_BASE  = 16384
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  freqWord,
  input  logic              phaseSel,
  input  logic              rtzEn,
  input  logic              initWe,
  input  logic [ADDR_W-1:0] initAddr,
  input  logic [DATA_W-1:0] initData,
  output logic [DATA_W-1:0] dacBus
);
  localparam int IDX_W = ACC_W - IDX_SHIFT;
  localparam logic [ADDR_W-IDX_W-1:0] BASE_HI = (ADDR_W - IDX_W)'(TBL_BASE >> IDX_W);

  ctlStb_t           stb;
  playState_t        ctlState;
  logic [DATA_W-1:0] heldVal;
  logic              sampleMsb;
  logic              freqZero;
  logic              tblWe;

  assign freqZero = (freqWord == '0);
  assign tblWe = initWe && (initAddr[ADDR_W-1:IDX_W] == BASE_HI);

  dds_ctrl #(.PERIOD(PERIOD), .GRP_LEN(GRP_LEN)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .phaseSel (phaseSel),
    .rtzEn    (rtzEn),
    .freqZero (freqZero),
    .sampleMsb(sampleMsb),
    .stb      (stb),
    .curState (ctlState)
  );

  dds_datapath #(.ACC_W(ACC_W), .IDX_SHIFT(IDX_SHIFT), .DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .freqWord (freqWord),
    .tblWe    (tblWe),
    .tblWrIdx (initAddr[IDX_W-1:0]),
    .tblWrData(initData),
    .dacBus   (dacBus),
    .heldVal  (heldVal),
    .sampleMsb(sampleMsb)
  );
endmodule

// File: rtl/dds_zc_player_chk.sv
module dds_zc_player_chk
  import dds_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              rtzEn,
  input logic [DATA_W-1:0] dacBus,
  input logic [DATA_W-1:0] heldVal,
  input ctlStb_t           stb,
  input playState_t        ctlState
);
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  a_r1_reset_mid: assert property (@(posedge clk)
    rst |=> (heldVal == MID && ctlState == ST_WAIT));

  a_r2_hold_between: assert property (@(posedge clk) disable iff (rst)
    !stb.tick |=> $stable(heldVal));

  a_r3_rtz_zero: assert property (@(posedge clk) disable iff (rst)
    (rtzEn && !stb.driveOn) |-> dacBus == '0);

  a_r5_inc_at_tick: assert property (@(posedge clk) disable iff (rst)
    (stb.incLoad || stb.accLoadNew || stb.accStep) |-> stb.tick);

  a_r6_single_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.outSample, stb.outMid, stb.accLoadNew}));

  a_r7_fade_exit: assert property (@(posedge clk) disable iff (rst)
    (ctlState == ST_FADE && stb.outMid) |=> (ctlState == ST_WAIT && heldVal == MID));

  a_r8_wait_mid: assert property (@(posedge clk) disable iff (rst)
    (ctlState == ST_WAIT) |-> heldVal == MID);
endmodule

bind dds_zc_player dds_zc_player_chk #(.DATA_W(DATA_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .rtzEn   (rtzEn),
  .dacBus  (dacBus),
  .heldVal (heldVal),
  .stb     (stb),
  .ctlState(ctlState)
);

// File: tb/dds_zc_player_tb.sv
module dds_zc_player_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;
  localparam logic [9:0] MID = 10'h200;
  localparam logic [31:0] STEP = 32'h0100_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] freqWord = '0;
  logic        phaseSel = 1'b0;
  logic        rtzEn = 1'b1;
  logic        initWe = 1'b0;
  logic [14:0] initAddr = '0;
  logic [9:0]  initData = '0;
  logic [9:0]  dacBus;

  int nChk = 0;
  int nBad = 0;

  // reference state, period granularity
  int          mState;
  logic [31:0] mAcc;
  logic [31:0] mInc;
  int          mGrp;
  logic        mSide;
  logic [7:0]  mRdIdx;
  logic [9:0]  mOut;
  string       tagA;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_zc_player dut_i (
    .clk(clk), .rst(rst), .freqWord(freqWord), .phaseSel(phaseSel),
    .rtzEn(rtzEn), .initWe(initWe), .initAddr(initAddr),
    .initData(initData), .dacBus(dacBus)
  );

  function automatic logic [9:0] tblVal(logic [7:0] i);
    return {i, 2'b00};
  endfunction

  task automatic chk(string tag, logic [9:0] act, logic [9:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: dacBus=%h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic resetModel();
    mState = 0; mAcc = '0; mInc = '0; mGrp = 0; mSide = 1'b0;
    mRdIdx = '0; mOut = MID;
  endtask

  task automatic modelEvent(logic [31:0] f);
    logic [9:0] rd;
    rd = tblVal(mRdIdx);
    case (mState)
      0: begin
        tagA = "R8";
        mRdIdx = mAcc[31:24];
        if (f != 0) begin
          mInc = f; mAcc = mAcc + f; mState = 1; mGrp = 0;
        end
      end
      1: begin
        mOut = rd;
        tagA = (mRdIdx == 0) ? "R9" : "R4";
        mRdIdx = mAcc[31:24];
        mAcc = mAcc + mInc;
        if (mGrp == 2) begin
          mGrp = 0;
          tagA = "R5";
          if (f == 0) begin mState = 2; mSide = rd[9]; end
          else mInc = f;
        end else mGrp++;
      end
      default: begin
        mRdIdx = mAcc[31:24];
        if (rd[9] != mSide) begin
          mOut = MID; mState = 0; tagA = "R7";
        end else begin
          mOut = rd; mAcc = mAcc + mInc; tagA = "R6";
        end
      end
    endcase
  endtask

  // entry: 1 time unit after the edge 8 counts before the boundary
  task automatic doPeriod(logic [31:0] f, logic rtz, string holdTag);
    freqWord = f;
    rtzEn = rtz;
    repeat (16) @(posedge clk);
    modelEvent(f);
    #1 chk(tagA, dacBus, mOut);
    repeat (6) @(posedge clk);
    #1 chk(holdTag, dacBus, mOut);
    repeat (10) @(posedge clk);
    #1 chk("R3", dacBus, rtz ? 10'h000 : mOut);
  endtask

  task automatic resetDut();
    rst = 1'b1;
    freqWord = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    resetModel();
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    nBad++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    // fill table during reset; R9 window writes
    repeat (2) @(posedge clk);
    #1;
    for (int i = 0; i < 256; i++) begin
      initWe = 1'b1; initAddr = 15'(16384 + i); initData = tblVal(8'(i));
      @(posedge clk); #1;
    end
    // out-of-window writes that alias index 0 (R9)
    initAddr = 15'(16384 + 256); initData = 10'h155;
    @(posedge clk); #1;
    initAddr = 15'(16384 - 256); initData = 10'h155;
    @(posedge clk); #1;
    initWe = 1'b0;

    // ---- run A: phaseSel low, boundary at count wrap
    phaseSel = 1'b0; rtzEn = 1'b1;
    resetDut();
    repeat (7) @(posedge clk);
    #1 chk("R1", dacBus, MID);
    repeat (16) @(posedge clk);
    #1 chk("R3", dacBus, 10'h000);
    for (int k = 0; k < 3; k++) doPeriod(32'h0, 1'b1, "R2");
    for (int k = 0; k < 10; k++) doPeriod(STEP * 5, 1'b1, "R2");
    for (int k = 0; k < 6; k++) doPeriod(STEP * 7, 1'b1, "R2");
    for (int k = 0; k < 6; k++) doPeriod(32'h00C0_0000, 1'b1, "R2");
    for (int k = 0; k < 6; k++) doPeriod(STEP * 9, 1'b1, "R2");
    for (int k = 0; k < 20; k++) doPeriod(32'h0, 1'b1, "R2");
    for (int k = 0; k < 8; k++) doPeriod(STEP * 3, 1'b1, "R2");
    for (int k = 0; k < 6; k++) doPeriod(STEP * 3, 1'b0, "R2");
    for (int k = 0; k < 50; k++) doPeriod(32'h0, 1'b1, "R2");

    // ---- run B: phaseSel high, boundary at count 16 (R10)
    phaseSel = 1'b1; rtzEn = 1'b0;
    resetDut();
    repeat (7) @(posedge clk);
    #1 chk("R1", dacBus, MID);
    for (int k = 0; k < 3; k++) doPeriod(32'h0, 1'b1, "R10");
    for (int k = 0; k < 10; k++) doPeriod(STEP * 6, 1'b1, "R10");
    for (int k = 0; k < 25; k++) doPeriod(32'h0, 1'b1, "R10");
    for (int k = 0; k < 4; k++) doPeriod(STEP * 11, 1'b0, "R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule